// File: doc/BRIEF.md
# External Bus Controller Indirect Configuration Port

This block gives software access to the configuration space of an external-bus controller through two registers on the device-control bus. One register holds an index. The other is a data window. A read of the data window returns the internal register that the index currently selects. The internal space is sparse. It holds a bank-control register for each memory bank, a bank-access-parameter register for each bank, an error address register, two error status registers and a global configuration register.

In this model the data window is read-only in effect. A write to it is accepted on the bus but changes nothing. The internal registers therefore keep their reset contents. The index register is a plain 32-bit read/write register. Each cycle carries at most one bus operation. Read data is registered and appears one cycle after the read strobe, together with a valid flag.

Software normally writes the index first and then reads the window. Because the window decode uses the index held at the start of the read cycle, a read placed directly after an index write already returns the newly selected register.

Top module: `extbus_cfg_port`

## Requirements
- R1: Bus register number 0x012 is the index register. A write to it stores all 32 data bits, and a read of it returns the stored value. Writes to any other bus number leave it unchanged.
- R2: A read strobe (`bus_vld`=1, `bus_wr`=0) produces `rd_valid`=1 with the read data on `rd_data` in the following cycle. `rd_valid` is 0 in every cycle that does not follow a read strobe.
- R3: With the index at 0x00–0x07 (bank-control registers 0–7) or 0x10–0x17 (bank-access registers 0–7), a read of the window at bus number 0x013 returns the selected register, which holds zero from reset.
- R4: Index 0x20 selects the error address register, and indices 0x21 and 0x22 select the two error status registers. All three read zero from reset.
- R5: Index 0x23 selects the global configuration register, which reads 0x80400000 from reset.
- R6: A window read with any index outside the decoded set (for example 0x08, 0x18, 0x24, 0xFFFFFFFF) returns zero.
- R7: A read of any bus number other than 0x012 and 0x013 returns zero, whatever the index holds.
- R8: A write through the data window at any index changes neither the internal registers nor the index register.
- R9: A window read uses the index held before its cycle. An index write followed by a window read in the very next cycle returns the newly indexed register.
- R10: After reset the index reads zero and `rd_valid` is 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_vld | input | 1 | A bus operation is present this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_num | input | ADDR_W | Bus register number |
| bus_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | `rd_data` holds the result of the previous cycle's read |

## Verification
The bench builds the block with its defaults: eight banks, the index at bus number 0x012, the window at 0x013 and a global configuration reset value of 0x80400000. With eight banks, both bank regions are fully populated. The holes 0x08–0x0F and 0x18–0x1F between the bank regions and the error group are therefore the nearest undecoded indices that can be reached. The configuration value is the only nonzero internal content. For that reason, window writes, misdecodes and leaks of the index onto unrelated bus numbers are tested against it as well as against the all-ones data written.

// File: rtl/extbus_cfg_pkg.sv
package extbus_cfg_pkg;

    localparam int unsigned BUS_AW  = 10;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned MAX_BANKS = 16;

    localparam logic [WORD_W-1:0] BACC_BASE  = 32'h10;
    localparam logic [WORD_W-1:0] EADR_IDX   = 32'h20;
    localparam logic [WORD_W-1:0] ESTAT0_IDX = 32'h21;
    localparam logic [WORD_W-1:0] ESTAT1_IDX = 32'h22;
    localparam logic [WORD_W-1:0] GCFG_IDX   = 32'h23;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BCTL,
        SEL_BACC,
        SEL_EADR,
        SEL_ESTAT0,
        SEL_ESTAT1,
        SEL_GCFG
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e  kind;
        logic [3:0] slot;
    } sel_t;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [BUS_AW-1:0] num;
        logic [WORD_W-1:0] data;
    } bus_op_t;

    function automatic sel_t decode_index(input logic [WORD_W-1:0] idx,
                                          input int unsigned       nbanks);
        sel_t s;
        s.kind = SEL_NONE;
        s.slot = idx[3:0];
        if (idx < WORD_W'(nbanks)) begin
            s.kind = SEL_BCTL;
        end else if (idx >= BACC_BASE && idx < BACC_BASE + WORD_W'(nbanks)) begin
            s.kind = SEL_BACC;
        end else begin
            case (idx)
                EADR_IDX:   s.kind = SEL_EADR;
                ESTAT0_IDX: s.kind = SEL_ESTAT0;
                ESTAT1_IDX: s.kind = SEL_ESTAT1;
                GCFG_IDX:   s.kind = SEL_GCFG;
                default:    s.kind = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/extbus_cfg_index.sv
module extbus_cfg_index
    import extbus_cfg_pkg::*;
#(
    parameter int unsigned              DATA_W  = WORD_W,
    parameter logic [BUS_AW-1:0]        IDX_NUM = 10'h012
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    output logic [DATA_W-1:0] index_q
);

    logic hit_wr;

    always_comb begin
        hit_wr = op.vld && op.wr && (op.num == IDX_NUM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= '0;
        end else if (hit_wr) begin
            index_q <= op.data;
        end
    end

endmodule

// File: rtl/extbus_cfg_regfile.sv
module extbus_cfg_regfile
    import extbus_cfg_pkg::*;
#(
    parameter int unsigned       NUM_BANKS = 8,
    parameter int unsigned       DATA_W    = WORD_W,
    parameter logic [WORD_W-1:0] GCFG_RST  = 32'h8040_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] index,
    output logic [DATA_W-1:0] win_data
);

    localparam int unsigned BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int unsigned NUM_ESTAT = 2;

    logic [DATA_W-1:0] bctl_q  [NUM_BANKS];
    logic [DATA_W-1:0] bacc_q  [NUM_BANKS];
    logic [DATA_W-1:0] estat_q [NUM_ESTAT];
    logic [DATA_W-1:0] eadr_q;
    logic [DATA_W-1:0] gcfg_q;
    sel_t              sel;
    logic [BSEL_W-1:0] bank;

    // Bank registers: loaded at reset, never written through the window.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                bctl_q[g] <= '0;
                bacc_q[g] <= '0;
            end
        end
    end

    for (genvar e = 0; e < NUM_ESTAT; e++) begin : g_estat
        always_ff @(posedge clk) begin
            if (rst) begin
                estat_q[e] <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eadr_q <= '0;
            gcfg_q <= GCFG_RST;
        end
    end

    always_comb begin
        sel  = decode_index(index, NUM_BANKS);
        bank = sel.slot[BSEL_W-1:0];
        case (sel.kind)
            SEL_BCTL:   win_data = bctl_q[bank];
            SEL_BACC:   win_data = bacc_q[bank];
            SEL_EADR:   win_data = eadr_q;
            SEL_ESTAT0: win_data = estat_q[0];
            SEL_ESTAT1: win_data = estat_q[1];
            SEL_GCFG:   win_data = gcfg_q;
            default:    win_data = '0;
        endcase
    end

endmodule

// File: rtl/extbus_cfg_rdport.sv
module extbus_cfg_rdport
    import extbus_cfg_pkg::*;
#(
    parameter int unsigned       DATA_W  = WORD_W,
    parameter logic [BUS_AW-1:0] IDX_NUM = 10'h012,
    parameter logic [BUS_AW-1:0] DAT_NUM = 10'h013
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  logic [DATA_W-1:0] index,
    input  logic [DATA_W-1:0] win_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic              is_rd;
    logic [DATA_W-1:0] mux_data;

    always_comb begin
        is_rd = op.vld && !op.wr;
        if (op.num == IDX_NUM) begin
            mux_data = index;
        end else if (op.num == DAT_NUM) begin
            mux_data = win_data;
        end else begin
            mux_data = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= is_rd;
            if (is_rd) begin
                rd_data <= mux_data;
            end
        end
    end

endmodule

// File: rtl/extbus_cfg_port.sv
module extbus_cfg_port
    import extbus_cfg_pkg::*;
#(
    parameter int unsigned       NUM_BANKS = 8,
    parameter int unsigned       ADDR_W    = BUS_AW,
    parameter int unsigned       DATA_W    = WORD_W,
    parameter logic [BUS_AW-1:0] IDX_NUM   = 10'h012,
    parameter logic [BUS_AW-1:0] DAT_NUM   = 10'h013,
    parameter logic [WORD_W-1:0] GCFG_RST  = 32'h8040_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_vld,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_num,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    bus_op_t           op;
    logic [DATA_W-1:0] index_q;
    logic [DATA_W-1:0] win_data;

    always_comb begin
        op.vld  = bus_vld;
        op.wr   = bus_wr;
        op.num  = bus_num;
        op.data = bus_wdata;
    end

    extbus_cfg_index #(
        .DATA_W  (DATA_W),
        .IDX_NUM (IDX_NUM)
    ) u_index (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .index_q (index_q)
    );

    extbus_cfg_regfile #(
        .NUM_BANKS (NUM_BANKS),
        .DATA_W    (DATA_W),
        .GCFG_RST  (GCFG_RST)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .index    (index_q),
        .win_data (win_data)
    );

    extbus_cfg_rdport #(
        .DATA_W  (DATA_W),
        .IDX_NUM (IDX_NUM),
        .DAT_NUM (DAT_NUM)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .index    (index_q),
        .win_data (win_data),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/extbus_cfg_port_chk.sv
module extbus_cfg_port_chk
    import extbus_cfg_pkg::*;
#(
    parameter int unsigned       ADDR_W   = BUS_AW,
    parameter int unsigned       DATA_W   = WORD_W,
    parameter logic [BUS_AW-1:0] IDX_NUM  = 10'h012,
    parameter logic [BUS_AW-1:0] DAT_NUM  = 10'h013,
    parameter logic [WORD_W-1:0] GCFG_RST = 32'h8040_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_vld,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_num,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic [DATA_W-1:0] index_q
);

    // R2
    rd_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_vld && !bus_wr) |=> rd_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(bus_vld && !bus_wr));

    // R1
    index_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_vld && bus_wr && bus_num == IDX_NUM) |=> index_q == $past(bus_wdata));

    // R8
    window_write_keeps_index_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_vld && bus_wr && bus_num == DAT_NUM) |=> $stable(index_q));

    // R5
    gcfg_value_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(bus_num == DAT_NUM && index_q == GCFG_IDX)) |-> rd_data == GCFG_RST);

    // R7
    other_num_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(bus_num != IDX_NUM && bus_num != DAT_NUM)) |-> rd_data == '0);

endmodule

bind extbus_cfg_port extbus_cfg_port_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IDX_NUM  (IDX_NUM),
    .DAT_NUM  (DAT_NUM),
    .GCFG_RST (GCFG_RST)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_vld   (bus_vld),
    .bus_wr    (bus_wr),
    .bus_num   (bus_num),
    .bus_wdata (bus_wdata),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .index_q   (index_q)
);

// File: tb/extbus_cfg_port_test.sv
module extbus_cfg_port_test;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [9:0]  IDX  = 10'h012;
    localparam logic [9:0]  DAT  = 10'h013;
    localparam logic [31:0] GCFG = 32'h8040_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_vld = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_num = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int fails  = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    extbus_cfg_port uut (
        .clk       (clk),
        .rst       (rst),
        .bus_vld   (bus_vld),
        .bus_wr    (bus_wr),
        .bus_num   (bus_num),
        .bus_wdata (bus_wdata),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Driver: one bus operation per cycle, issued at the falling edge.
    task automatic wr_op(input logic [9:0] num, input logic [31:0] d);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b1; bus_num = num; bus_wdata = d;
    endtask

    task automatic rd_op(input logic [9:0] num, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b0; bus_num = num; bus_wdata = '0;
        exp_q.push_back(exp);
        tag_q.push_back(req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_vld = 1'b0; bus_wr = 1'b0;
        end
    endtask

    // Monitor: pops one expectation for each valid read result.
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R2: actual rd_valid=1 expected rd_valid=0 (no read pending)");
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rd_data, e);
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: no valid while reset held
        check("R10", {31'b0, rd_valid}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R10: index reads zero after reset
        rd_op(IDX, 32'h0, "R10");

        // R1: full-width index write and read back
        wr_op(IDX, 32'hA5A5_0017);
        rd_op(IDX, 32'hA5A5_0017, "R1");
        wr_op(IDX, 32'hFFFF_FFFF);
        rd_op(IDX, 32'hFFFF_FFFF, "R1");
        wr_op(10'h011, 32'h1234_5678);
        rd_op(IDX, 32'hFFFF_FFFF, "R1 other-num write");
        idle(2);

        // R3: bank-control and bank-access regions (back-to-back, R9)
        for (int i = 0; i < 8; i++) begin
            wr_op(IDX, 32'(i));
            rd_op(DAT, 32'h0, "R3 bank ctl");
            wr_op(IDX, 32'h10 + 32'(i));
            rd_op(DAT, 32'h0, "R3 bank acc");
        end

        // R4: error registers
        wr_op(IDX, 32'h20); rd_op(DAT, 32'h0, "R4 err addr");
        wr_op(IDX, 32'h21); rd_op(DAT, 32'h0, "R4 err stat0");
        wr_op(IDX, 32'h22); rd_op(DAT, 32'h0, "R4 err stat1");

        // R5: global configuration
        wr_op(IDX, 32'h23); rd_op(DAT, GCFG, "R5");
        rd_op(DAT, GCFG, "R5 repeat");

        // R6: undecoded indices
        wr_op(IDX, 32'h08); rd_op(DAT, 32'h0, "R6 0x08");
        wr_op(IDX, 32'h0F); rd_op(DAT, 32'h0, "R6 0x0F");
        wr_op(IDX, 32'h18); rd_op(DAT, 32'h0, "R6 0x18");
        wr_op(IDX, 32'h24); rd_op(DAT, 32'h0, "R6 0x24");
        wr_op(IDX, 32'h123); rd_op(DAT, 32'h0, "R6 0x123");
        wr_op(IDX, 32'hFFFF_FFFF); rd_op(DAT, 32'h0, "R6 all-ones");

        // R9: index switches between back-to-back window reads
        wr_op(IDX, 32'h23); rd_op(DAT, GCFG, "R9 to gcfg");
        wr_op(IDX, 32'h20); rd_op(DAT, 32'h0, "R9 to err addr");
        wr_op(IDX, 32'h23); rd_op(DAT, GCFG, "R9 back to gcfg");

        // R7: other bus numbers read zero while index selects gcfg
        rd_op(10'h011, 32'h0, "R7 0x011");
        rd_op(10'h014, 32'h0, "R7 0x014");
        rd_op(10'h000, 32'h0, "R7 0x000");
        rd_op(10'h3FF, 32'h0, "R7 0x3FF");
        idle(2);

        // R8: window writes at every decoded index change nothing
        for (int i = 0; i < 8; i++) begin
            wr_op(IDX, 32'(i));
            wr_op(DAT, 32'hFFFF_FFFF);
            rd_op(DAT, 32'h0, "R8 bank ctl");
            rd_op(IDX, 32'(i), "R8 index kept");
            wr_op(IDX, 32'h10 + 32'(i));
            wr_op(DAT, 32'hFFFF_FFFF);
            rd_op(DAT, 32'h0, "R8 bank acc");
        end
        for (int i = 0; i < 4; i++) begin
            wr_op(IDX, 32'h20 + 32'(i));
            wr_op(DAT, 32'h5A5A_5A5A);
        end
        wr_op(IDX, 32'h20); rd_op(DAT, 32'h0, "R8 err addr");
        wr_op(IDX, 32'h21); rd_op(DAT, 32'h0, "R8 err stat0");
        wr_op(IDX, 32'h22); rd_op(DAT, 32'h0, "R8 err stat1");
        wr_op(IDX, 32'h23); rd_op(DAT, GCFG, "R8 gcfg");
        wr_op(DAT, 32'h0);
        rd_op(DAT, GCFG, "R8 gcfg after zero write");

        idle(4);
        // R2: every read produced exactly one valid result
        check("R2 pending reads", 32'(exp_q.size()), 32'h0);

        summary();
        $finish;
    end

endmodule